// File: doc/BRIEF.md
# Steerable Bridge PWM Generator

This block makes one pulse-width modulated waveform from an 8-bit up-counting timer behind a clock prescaler. A period register sets where the timer wraps. A 10-bit on-time value is compared against the timer, which is widened by two fractional bits taken from the prescaler phase. The waveform is then routed onto four output pins, named A to D. The routing can be a single output, a half-bridge pair with a complementary signal, or a full bridge driven in either direction. Each pin pair has its own polarity, and in half-bridge routing each output is held off for a programmable number of clock cycles after it is asked to turn on.

Software programs the block through a write-only register port. A clock-enable input stands in for sleep: while it is low, nothing inside moves and the pins keep their levels. A one-cycle timer flag marks each wrap of the timer.

Register map (address: contents). 0: period (8 bits). 1: upper 8 bits of the on-time. 2: bits[1:0] lower 2 bits of the on-time, bits[3:2] routing mode, bit 4 A/C polarity, bit 5 B/D polarity. 3: dead band in bits[6:0]. 4: bits[1:0] prescale code, bit 2 timer run.

Top module: `bridge_pwm`

## Requirements
- R1: After reset, all pins are low, the flag is low, the period register is 255, the on-time is 0, routing is single (pin A only) with active-high polarity, and the timer is stopped.
- R2: With the timer running, one period lasts (P+1)·div clock cycles for period value P, and the flag pulses for exactly one cycle per period.
- R3: Prescale code 0 gives div 1, code 1 gives div 4, and codes 2 and 3 give div 16.
- R4: With on-time D, the number of active cycles per period is min(P+1, ceil(D/4)) for div 1, min(4(P+1), D) for div 4, and 4·min(4(P+1), D) for div 16.
- R5: An on-time of 0 keeps the modulated output inactive, and an on-time greater than 4P+3 keeps it active for the whole period.
- R6: Writes to the period and on-time registers take effect only when the timer wraps to zero, or at once while the timer is stopped.
- R7: Routing mode 00 modulates A and holds B, C and D inactive. Mode 01 (forward) holds A active, modulates D, and holds B and C inactive. Mode 10 (half-bridge) modulates A and drives B with the complement. Mode 11 (reverse) holds C active, modulates B, and holds A and D inactive.
- R8: A polarity bit of 1 makes its pins (A and C for bit 4, B and D for bit 5) active-low, so that the inactive level is 1.
- R9: In half-bridge routing with dead band N, every change of the modulated signal holds both A and B inactive for N clock cycles. A then gets max(0, D'−N) active cycles per period, where D' is the active count from R4, and B gets max(0, T−D'−N), where T is the period length in cycles.
- R10: If the dead band is longer than an active phase, that output stays inactive for the whole phase, and the dead band of the next phase counts from its own start.
- R11: While the clock enable is low, the timer, the pins, the flag and all registers hold, register writes are ignored, and operation resumes from the held state.
- R12: While the run bit is 0, the timer stays at zero, the flag stays low and the pins stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable; low models sleep |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| pwmPins | output | 4 | Output pins, bit 0 = A up to bit 3 = D |
| tmrFlag | output | 1 | One-cycle pulse at each timer wrap |

## Verification
A wrong timer or prescaler state shows up within one period as a flag spacing that differs from (P+1)·div. A wrong compare or shadow state changes the count of active cycles in the very next period. A stuck or mis-loaded dead band counter changes the A and B counts in half-bridge routing within one phase. A gating fault on the clock enable moves a pin during the sleep window, or shifts the next flag by the wrong number of cycles. The bench therefore sweeps on-time, prescale and dead band over a small period, and compares per-period counts and flag spacings against closed-form values.

// File: rtl/bridge_pwm_pkg.sv
package bridge_pwm_pkg;

  localparam int NUM_OUT = 4;
  localparam int PS_W    = 4;

  // register addresses
  localparam int A_PERIOD  = 0;
  localparam int A_DUTY_HI = 1;
  localparam int A_CONFIG  = 2;
  localparam int A_DBAND   = 3;
  localparam int A_TIMER   = 4;

  typedef enum logic [1:0] {
    STEER_SINGLE = 2'b00,
    STEER_FWD    = 2'b01,
    STEER_HALF   = 2'b10,
    STEER_REV    = 2'b11
  } steer_e;

  typedef struct packed {
    logic adv;       // clock enable: state may move this cycle
    logic rollover;  // timer wraps to zero at this edge
  } pwm_strobe_t;

endpackage

// File: rtl/bridge_pwm_ctrl.sv
module bridge_pwm_ctrl
  import bridge_pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int DB_W   = 7,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output pwm_strobe_t       strobe,
  output logic [DUTY_W-1:0] position,
  output logic [DUTY_W-1:0] dutyLive,
  output steer_e            steer,
  output logic              polAC,
  output logic              polBD,
  output logic [DB_W-1:0]   deadBand,
  output logic              tmrFlag
);

  logic [TMR_W-1:0]  periodReg, periodAct, tmr;
  logic [TMR_W-1:0]  dutyHiReg;
  logic [FRAC_W-1:0] dutyLoReg;
  logic [DUTY_W-1:0] dutyAct;
  logic [1:0]        psSel;
  logic              runBit;
  logic [PS_W-1:0]   psCnt, divMax;
  logic [FRAC_W-1:0] fine;
  logic              tick, rollover, loadShadow;

  // register writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '1;
      dutyHiReg <= '0;
      dutyLoReg <= '0;
      steer     <= STEER_SINGLE;
      polAC     <= 1'b0;
      polBD     <= 1'b0;
      deadBand  <= '0;
      psSel     <= '0;
      runBit    <= 1'b0;
    end else if (clkEn && wrEn) begin
      if (wrAddr == ADDR_W'(A_PERIOD))  periodReg <= wrData[TMR_W-1:0];
      if (wrAddr == ADDR_W'(A_DUTY_HI)) dutyHiReg <= wrData[TMR_W-1:0];
      if (wrAddr == ADDR_W'(A_CONFIG)) begin
        dutyLoReg <= wrData[FRAC_W-1:0];
        steer     <= steer_e'(wrData[3:2]);
        polAC     <= wrData[4];
        polBD     <= wrData[5];
      end
      if (wrAddr == ADDR_W'(A_DBAND))   deadBand  <= wrData[DB_W-1:0];
      if (wrAddr == ADDR_W'(A_TIMER)) begin
        psSel  <= wrData[1:0];
        runBit <= wrData[2];
      end
    end
  end

  // prescaler terminal count
  always_comb begin
    case (psSel)
      2'd0:    divMax = PS_W'(0);
      2'd1:    divMax = PS_W'(3);
      default: divMax = PS_W'(15);
    endcase
  end

  // fractional compare bits from the prescaler phase
  always_comb begin
    case (psSel)
      2'd0:    fine = '0;
      2'd1:    fine = psCnt[1:0];
      default: fine = psCnt[3:2];
    endcase
  end

  assign tick       = runBit && (psCnt >= divMax);
  assign rollover   = tick && (tmr >= periodAct);
  assign loadShadow = !runBit || rollover;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt     <= '0;
      tmr       <= '0;
      periodAct <= '1;
      dutyAct   <= '0;
      tmrFlag   <= 1'b0;
    end else if (clkEn) begin
      if (!runBit || tick) psCnt <= '0;
      else                 psCnt <= psCnt + 1'b1;
      if (!runBit || rollover) tmr <= '0;
      else if (tick)           tmr <= tmr + 1'b1;
      if (loadShadow) begin
        periodAct <= periodReg;
        dutyAct   <= {dutyHiReg, dutyLoReg};
      end
      tmrFlag <= rollover;
    end
  end

  assign position        = {tmr, fine};
  assign dutyLive        = dutyAct;
  assign strobe.adv      = clkEn;
  assign strobe.rollover = clkEn && rollover;

  // R2
  tmr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tmr <= periodAct);

  // R2
  roll_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rollover |=> (tmr == '0) && tmrFlag);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && clkEn) |=> (tmr == '0) && !tmrFlag);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && !rollover) |=> $stable(periodAct) && $stable(dutyAct));

  // R11
  sleep_timer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(tmr) && $stable(psCnt) && $stable(periodReg));

endmodule

// File: rtl/bridge_pwm_dp.sv
module bridge_pwm_dp
  import bridge_pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int DB_W   = 7,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwm_strobe_t       strobe,
  input  logic [DUTY_W-1:0] position,
  input  logic [DUTY_W-1:0] dutyLive,
  input  steer_e            steer,
  input  logic              polAC,
  input  logic              polBD,
  input  logic [DB_W-1:0]   deadBand,
  output logic [NUM_OUT-1:0] pinsQ
);

  logic               raw, rawQ, rawEdge, dbHold;
  logic [DB_W-1:0]    dbCnt;
  logic [NUM_OUT-1:0] act, pinsNext;

  assign raw     = position < dutyLive;
  assign rawEdge = raw ^ rawQ;
  assign dbHold  = (rawEdge && (deadBand != '0)) || (dbCnt != '0);

  // dead band counter, reloaded on every change of the modulated signal
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ  <= 1'b0;
      dbCnt <= '0;
    end else if (strobe.adv) begin
      rawQ <= raw;
      if (rawEdge)           dbCnt <= (deadBand != '0) ? DB_W'(deadBand - 1'b1) : '0;
      else if (dbCnt != '0)  dbCnt <= dbCnt - 1'b1;
    end
  end

  // routing, bit 0 = A .. bit 3 = D
  always_comb begin
    act = '0;
    case (steer)
      STEER_SINGLE: act[0] = raw;
      STEER_FWD: begin
        act[0] = 1'b1;
        act[3] = raw;
      end
      STEER_HALF: begin
        act[0] = raw  && !dbHold;
        act[1] = !raw && !dbHold;
      end
      STEER_REV: begin
        act[2] = 1'b1;
        act[1] = raw;
      end
      default: act = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pol
    assign pinsNext[i] = act[i] ^ (((i % 2) == 1) ? polBD : polAC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pinsQ <= '0;
    else if (strobe.adv) pinsQ <= pinsNext;
  end

  // R11
  sleep_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.adv |=> $stable(pinsQ));

  // R9
  dband_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.adv && steer == STEER_HALF && rawEdge && deadBand != '0)
      |=> pinsQ[1:0] == $past({polBD, polAC}));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.adv && steer == STEER_SINGLE && dutyLive == '0)
      |=> pinsQ[0] == $past(polAC));

  // R7
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.adv && strobe.rollover && steer == STEER_FWD)
      |=> pinsQ[0] == !$past(polAC));

endmodule

// File: rtl/bridge_pwm.sv
module bridge_pwm
  import bridge_pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int DB_W   = 7,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [3:0]        pwmPins,
  output logic              tmrFlag
);

  pwm_strobe_t       strobe;
  logic [DUTY_W-1:0] position, dutyLive;
  steer_e            steer;
  logic              polAC, polBD;
  logic [DB_W-1:0]   deadBand;

  bridge_pwm_ctrl #(
    .TMR_W(TMR_W), .FRAC_W(FRAC_W), .DB_W(DB_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .position(position), .dutyLive(dutyLive),
    .steer(steer), .polAC(polAC), .polBD(polBD),
    .deadBand(deadBand), .tmrFlag(tmrFlag)
  );

  bridge_pwm_dp #(
    .TMR_W(TMR_W), .FRAC_W(FRAC_W), .DB_W(DB_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .position(position), .dutyLive(dutyLive),
    .steer(steer), .polAC(polAC), .polBD(polBD),
    .deadBand(deadBand), .pinsQ(pwmPins)
  );

endmodule

// File: tb/bridge_pwm_tb.sv
module bridge_pwm_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkEn = 1'b1;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] pwmPins;
  logic       tmrFlag;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  bridge_pwm u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pwmPins(pwmPins), .tmrFlag(tmrFlag)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfg(int p, int ps, int d, int st, int pAC, int pBD, int db);
    wr(0, p);
    wr(1, d >> 2);
    wr(2, (d & 3) | (st << 2) | (pAC << 4) | (pBD << 5));
    wr(3, db);
    wr(4, ps | 4);
  endtask

  task automatic waitFlag();
    do @(negedge clk); while (tmrFlag !== 1'b1);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (tmrFlag !== 1'b1);
  endtask

  task automatic measure(int t, output int hA, output int hB, output int hC, output int hD);
    hA = 0; hB = 0; hC = 0; hD = 0;
    waitFlag();
    waitFlag();
    for (int i = 0; i < t; i++) begin
      @(negedge clk);
      hA += int'(pwmPins[0]); hB += int'(pwmPins[1]);
      hC += int'(pwmPins[2]); hD += int'(pwmPins[3]);
    end
  endtask

  function automatic int divOf(int ps);
    return (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int onCycles(int p, int ps, int d);
    if (ps == 0)      return imin(p + 1, (d + 3) / 4);
    else if (ps == 1) return imin(4 * (p + 1), d);
    else              return 4 * imin(4 * (p + 1), d);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int hA, hB, hC, hD, t, e, n, mism;
    logic [3:0] snap;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins after reset", int'(pwmPins), 0);
    check("R1 flag after reset", int'(tmrFlag), 0);

    // R12 timer stopped after reset: no flag, pins constant
    mism = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tmrFlag !== 1'b0 || pwmPins !== 4'b0000) mism++;
    end
    check("R12 idle after reset", mism, 0);

    // R1 default period 255 at div 1
    wr(4, 4);
    waitFlag();
    gap(n);
    check("R1 default period", n, 256);
    check("R1 default duty keeps A low", int'(pwmPins), 0);

    // R3 / R2 flag spacing for every prescale code
    for (int ps = 0; ps < 4; ps++) begin
      cfg(4, ps, 5, 0, 0, 0, 0);
      waitFlag();
      waitFlag();
      gap(n);
      check($sformatf("R3 period ps=%0d", ps), n, 5 * divOf(ps));
    end

    // R2 flag is a one-cycle pulse
    waitFlag();
    @(negedge clk);
    check("R2 flag width", int'(tmrFlag), 0);

    // R4 / R5 sweep in single routing
    for (int ps = 0; ps < 3; ps++) begin
      for (int d = 0; d < 18; d++) begin
        t = 4 * divOf(ps);
        cfg(3, ps, d, 0, 0, 0, 0);
        measure(t, hA, hB, hC, hD);
        e = onCycles(3, ps, d);
        check($sformatf("R4 ps=%0d d=%0d A", ps, d), hA, e);
        check($sformatf("R7 single ps=%0d d=%0d BCD", ps, d), hB + hC + hD, 0);
        if (d == 0)  check("R5 zero duty", hA, 0);
        if (d > 15)  check("R5 over-period duty", hA, t);
      end
    end
    for (int d = 0; d < 40; d += 3) begin
      cfg(7, 0, d, 0, 0, 0, 0);
      measure(8, hA, hB, hC, hD);
      check($sformatf("R4 P=7 d=%0d A", d), hA, onCycles(7, 0, d));
    end

    // R7 forward and reverse routing
    for (int d = 0; d < 18; d += 5) begin
      cfg(3, 1, d, 1, 0, 0, 0);
      measure(16, hA, hB, hC, hD);
      check($sformatf("R7 fwd d=%0d A", d), hA, 16);
      check($sformatf("R7 fwd d=%0d D", d), hD, onCycles(3, 1, d));
      check($sformatf("R7 fwd d=%0d BC", d), hB + hC, 0);
      cfg(3, 1, d, 3, 0, 0, 0);
      measure(16, hA, hB, hC, hD);
      check($sformatf("R7 rev d=%0d C", d), hC, 16);
      check($sformatf("R7 rev d=%0d B", d), hB, onCycles(3, 1, d));
      check($sformatf("R7 rev d=%0d AD", d), hA + hD, 0);
    end

    // R8 polarity
    cfg(3, 1, 6, 0, 1, 1, 0);
    measure(16, hA, hB, hC, hD);
    check("R8 single A low-active", hA, 16 - 6);
    check("R8 single BCD idle high", hB + hC + hD, 48);
    cfg(3, 1, 6, 1, 0, 1, 0);
    measure(16, hA, hB, hC, hD);
    check("R8 fwd A", hA, 16);
    check("R8 fwd D low-active", hD, 16 - 6);
    check("R8 fwd B idle high", hB, 16);
    check("R8 fwd C idle low", hC, 0);

    // R9 half-bridge dead band sweep
    for (int db = 0; db < 7; db += 2) begin
      for (int d = 1; d < 16; d++) begin
        cfg(3, 1, d, 2, 0, 0, db);
        measure(16, hA, hB, hC, hD);
        e = d - db;
        check($sformatf("R9 d=%0d db=%0d A", d, db), hA, (e > 0) ? e : 0);
        e = 16 - d - db;
        check($sformatf("R9 d=%0d db=%0d B", d, db), hB, (e > 0) ? e : 0);
        check($sformatf("R9 d=%0d db=%0d CD", d, db), hC + hD, 0);
      end
    end
    // R10 dead band longer than the active phase
    cfg(3, 1, 4, 2, 0, 0, 9);
    measure(16, hA, hB, hC, hD);
    check("R10 A suppressed", hA, 0);
    check("R10 B after own delay", hB, 3);
    // R9 no edges at full duty: no dead band
    cfg(3, 1, 20, 2, 0, 0, 3);
    measure(16, hA, hB, hC, hD);
    check("R9 full duty A", hA, 16);
    check("R9 full duty B", hB, 0);

    // R6 shadowed period write
    cfg(7, 0, 16, 0, 0, 0, 0);
    waitFlag();
    waitFlag();
    n = 0;
    @(negedge clk); n++;
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'd15;
    @(negedge clk); n++;
    wrEn = 1'b0;
    while (tmrFlag !== 1'b1) begin @(negedge clk); n++; end
    check("R6 old period kept", n, 8);
    gap(n);
    check("R6 new period applied", n, 16);

    // R11 sleep
    cfg(3, 1, 6, 0, 0, 0, 0);
    waitFlag();
    waitFlag();
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    clkEn = 1'b0;
    snap = pwmPins;
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'd0;
    mism = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); n++;
      if (pwmPins !== snap || tmrFlag !== 1'b0) mism++;
    end
    clkEn = 1'b1;
    wrEn = 1'b0;
    check("R11 pins held in sleep", mism, 0);
    while (tmrFlag !== 1'b1) begin @(negedge clk); n++; end
    check("R11 period stretched by sleep", n, 36);
    gap(n);
    check("R11 write ignored in sleep", n, 16);

    // R12 run bit cleared
    wr(4, 1);
    @(negedge clk);
    snap = pwmPins;
    mism = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (tmrFlag !== 1'b0 || pwmPins !== snap) mism++;
    end
    check("R12 stopped timer holds", mism, 0);
    check("R12 pin A active at timer zero", int'(snap[0]), 1);

    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule